// File: doc/BRIEF.md
# Dual-Clock Sine Lookup Generator

This block produces two sine waves at the same time from one shared read-only table of signed samples. Each of its two read ports has its own clock and its own free-running phase counter. Each counter steps once per clock of its port, so each wave's frequency is the port clock rate divided by the table depth. When port B is fed a clock at twice port A's rate, wave B runs at twice the frequency of wave A.

The table covers one full sine period. It is computed by a constant function when the design is elaborated, so no initialisation file is needed. One active-low reset clears both ports at once, without waiting for a clock. Each port leaves reset on its own clock, through a private two-flop synchroniser. Every port shows its current phase next to the sample stored at that phase, on the same cycle.

Top module: `dual_clock_sine_source`

## Requirements
- R1: Once running, each port's `addr_*` output advances by exactly one on every rising edge of that port's own clock, with no enable input. After the last phase (1023 with defaults) it returns to 0.
- R2: The sample shown for phase k is round(1023·sin(2πk/1024)), with halves rounded away from zero. It is an 11-bit two's-complement value with the sign in bit 10, so it lies in −1023..+1023 and the code −1024 never appears.
- R3: `sample_*` is always the table entry for the `addr_*` value shown on the same cycle. In particular, phase 0 shows 0 and phase 256 shows +1023.
- R4: The two ports run independently. Port A's sequence is the same whatever port B does. With clk_b at twice clk_a's rate, port B steps through its phases twice as often as port A.
- R5: While `arst_n` is low, both ports show address 0 and sample 0. These values appear as soon as `arst_n` falls, with no clock edge needed.
- R6: After `arst_n` rises, each port still shows address 0 following the first three rising edges of its own clock. It shows address 1 after the fourth edge, and one more per edge from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A and its phase counter |
| clk_b | input | 1 | Clock of port B and its phase counter |
| arst_n | input | 1 | Asynchronous active-low reset for both ports |
| addr_a | output | 10 | Phase currently shown on port A |
| sample_a | output | 11 | Signed sine sample for addr_a |
| addr_b | output | 10 | Phase currently shown on port B |
| sample_b | output | 11 | Signed sine sample for addr_b |

## Verification
Results follow a fixed cycle count after reset release. The synchroniser takes two edges, the counter one more, and the registered address and data one more. So a port's fourth edge after release is the first to show phase 1, and each later edge shows the next phase with its sample. The bench queues the expected phase and sample for every edge of each clock, starting at release. Each port's monitor samples one nanosecond after its own rising edge and pops one item per edge. Both monitors run at once, so a slip in either domain shows up as a mismatch on that port alone. The reset outputs are read between edges, shortly after `arst_n` falls, because they do not wait for a clock.

// File: rtl/dual_clock_sine_source.sv
module dual_clock_sine_source #(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 11
) (
  input  logic                       clk_a,
  input  logic                       clk_b,
  input  logic                       arst_n,
  output logic [ADDR_W-1:0]          addr_a,
  output logic signed [SAMPLE_W-1:0] sample_a,
  output logic [ADDR_W-1:0]          addr_b,
  output logic signed [SAMPLE_W-1:0] sample_b
);
  localparam int  DEPTH = 2 ** ADDR_W;
  localparam int  AMP   = 2 ** (SAMPLE_W - 1) - 1;
  localparam real PI    = 3.14159265358979323846;

  function automatic logic [DEPTH*SAMPLE_W-1:0] build_table();
    logic [DEPTH*SAMPLE_W-1:0] t;
    real x, term, s, v;
    int  r;
    t = '0;
    for (int k = 0; k < DEPTH; k++) begin
      x = 2.0 * PI * k / DEPTH;
      if (x > PI) x = x - 2.0 * PI;
      term = x;
      s = x;
      for (int n = 1; n <= 12; n++) begin
        term = -term * x * x / ((2.0 * n) * (2.0 * n + 1.0));
        s = s + term;
      end
      v = AMP * s;
      if (v >= 0.0) r = $rtoi(v + 0.5);
      else          r = -$rtoi(0.5 - v);
      t[k*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(r);
    end
    return t;
  endfunction

  localparam logic [DEPTH*SAMPLE_W-1:0] SINE_TABLE = build_table();

  logic [1:0] clk_v;
  assign clk_v = {clk_b, clk_a};

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [1:0]          sync_q;
    logic [ADDR_W-1:0]   phase_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [SAMPLE_W-1:0] samp_q;

    always_ff @(posedge clk_v[p] or negedge arst_n)
      if (!arst_n) sync_q <= 2'b00;
      else         sync_q <= {sync_q[0], 1'b1};

    always_ff @(posedge clk_v[p] or negedge arst_n)
      if (!arst_n)        phase_q <= '0;
      else if (sync_q[1]) phase_q <= phase_q + 1'b1;

    always_ff @(posedge clk_v[p] or negedge arst_n)
      if (!arst_n) begin
        addr_q <= '0;
        samp_q <= '0;
      end else begin
        addr_q <= phase_q;
        samp_q <= SINE_TABLE[int'(phase_q)*SAMPLE_W +: SAMPLE_W];
      end
  end

  assign addr_a   = g_port[0].addr_q;
  assign sample_a = g_port[0].samp_q;
  assign addr_b   = g_port[1].addr_q;
  assign sample_b = g_port[1].samp_q;
endmodule

// File: rtl/dual_clock_sine_source_chk.sv
module dual_clock_sine_source_chk #(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 11
) (
  input logic                       clk_a,
  input logic                       clk_b,
  input logic                       arst_n,
  input logic [ADDR_W-1:0]          addr_a,
  input logic signed [SAMPLE_W-1:0] sample_a,
  input logic [ADDR_W-1:0]          addr_b,
  input logic signed [SAMPLE_W-1:0] sample_b
);
  localparam logic [ADDR_W-1:0]   LAST    = '1;
  localparam logic [ADDR_W-1:0]   QUARTER = ADDR_W'(2 ** (ADDR_W - 2));
  localparam logic [SAMPLE_W-1:0] PEAK    = SAMPLE_W'(2 ** (SAMPLE_W - 1) - 1);
  localparam logic [SAMPLE_W-1:0] MINCODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  a_r1_step_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    (addr_a != '0) |-> (addr_a == $past(addr_a) + 1'b1));
  a_r1_wrap_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    ($past(addr_a) == LAST) |-> (addr_a == '0));
  a_r2_no_min_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    sample_a != MINCODE);
  a_r3_zero_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    (addr_a == '0) |-> (sample_a == '0));
  a_r3_peak_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    (addr_a == QUARTER) |-> (sample_a == PEAK));

  a_r1_step_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    (addr_b != '0) |-> (addr_b == $past(addr_b) + 1'b1));
  a_r1_wrap_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    ($past(addr_b) == LAST) |-> (addr_b == '0));
  a_r2_no_min_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    sample_b != MINCODE);
  a_r3_zero_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    (addr_b == '0) |-> (sample_b == '0));
  a_r3_peak_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    (addr_b == QUARTER) |-> (sample_b == PEAK));
endmodule

bind dual_clock_sine_source dual_clock_sine_source_chk #(
  .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)
) u_chk (.*);

// File: tb/dual_clock_sine_source_bench.sv
`timescale 1ns/1ps
module dual_clock_sine_source_bench;
  localparam int  ADDR_W   = 10;
  localparam int  SAMPLE_W = 11;
  localparam int  DEPTH    = 2 ** ADDR_W;
  localparam int  AMP      = 2 ** (SAMPLE_W - 1) - 1;
  localparam real CLK_A_PERIOD = 10.0;
  localparam real CLK_B_PERIOD = CLK_A_PERIOD / 2.0;

  logic clk_a = 0, clk_b = 0, arst_n = 0;
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic signed [SAMPLE_W-1:0] sample_a, sample_b;

  dual_clock_sine_source #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_dual_clock_sine_source (
    .clk_a(clk_a), .clk_b(clk_b), .arst_n(arst_n),
    .addr_a(addr_a), .sample_a(sample_a), .addr_b(addr_b), .sample_b(sample_b));

  always #(CLK_A_PERIOD/2.0) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2.0) clk_b = ~clk_b;

  int checks = 0, failures = 0;
  bit act = 0, done = 0;
  int qa_addr[$], qa_samp[$], qb_addr[$], qb_samp[$];

  function automatic int ref_sine(int k);
    real v;
    v = AMP * $sin(2.0 * 3.14159265358979323846 * k / DEPTH);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  // item i is what a port shows after the i-th own edge since release (R6)
  task automatic push_expect(bit port_b, int n);
    for (int i = 1; i <= n; i++) begin
      int a;
      a = (i < 4) ? 0 : (i - 3) % DEPTH;
      if (port_b) begin qb_addr.push_back(a); qb_samp.push_back(ref_sine(a)); end
      else        begin qa_addr.push_back(a); qa_samp.push_back(ref_sine(a)); end
    end
  endtask

  task automatic check(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor, port A: R1 R2 R3 R6
  initial forever begin
    @(posedge clk_a); #1;
    if (act && qa_addr.size() > 0) begin
      check("R1/R6 addr_a", int'(addr_a), qa_addr.pop_front());
      check("R2/R3 sample_a", int'(sample_a), qa_samp.pop_front());
    end
  end

  // monitor, port B: R4 twice-rate port, plus R1 R2 R3 R6
  initial forever begin
    @(posedge clk_b); #1;
    if (act && qb_addr.size() > 0) begin
      check("R4/R1/R6 addr_b", int'(addr_b), qb_addr.pop_front());
      check("R4/R2/R3 sample_b", int'(sample_b), qb_samp.pop_front());
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #20;
    check("R5 reset addr_a", int'(addr_a), 0);
    check("R5 reset sample_a", int'(sample_a), 0);
    check("R5 reset addr_b", int'(addr_b), 0);
    check("R5 reset sample_b", int'(sample_b), 0);
    push_expect(0, 2100);
    push_expect(1, 4200);
    #81;
    arst_n = 1; act = 1;
    wait (qa_addr.size() == 0 && qb_addr.size() == 0);

    @(posedge clk_a); #3;
    arst_n = 0; act = 0;
    #1;
    check("R5 async addr_a", int'(addr_a), 0);
    check("R5 async sample_a", int'(sample_a), 0);
    check("R5 async addr_b", int'(addr_b), 0);
    check("R5 async sample_b", int'(sample_b), 0);

    push_expect(0, 60);
    push_expect(1, 120);
    @(posedge clk_a); #6;
    arst_n = 1; act = 1;
    wait (qa_addr.size() == 0 && qb_addr.size() == 0);
    #2;
    finish_run();
  end
endmodule